// File: doc/BRIEF.md
# Address-Triggered Load/Store Execution Unit

This block executes decoded register instructions for a machine with three register banks: eight 60-bit operand registers X0..X7, eight 18-bit address registers A0..A7 and eight 18-bit index registers B0..B7. It has no load or store opcodes. Memory traffic is a side effect of writing an address register. A new value in A1..A5 fetches the word at that address into the X register with the same number. A new value in A6 or A7 writes the same-numbered X register to that address. Arithmetic on X and B registers never reaches memory.

Instructions arrive one per handshake on a decoded port: opcode, destination i, sources j and k, and an 18-bit displacement. The memory side is a single word-addressed request/acknowledge port, and at most one transfer is in flight. An instruction is held off only when it would race that transfer. This covers another address-register write, and any read or write of the X register that is still waiting for load data. A zero test on an index register reports its outcome one cycle after acceptance, so that a counted loop with an index starting at -n can stop when the index reaches zero.

Top module: `areg_lsu`

## Requirements
- R1: After reset all registers read as zero, mem_req_o and jz_valid_o are low and instr_ready_o is high.
- R2: Opcode 0x01 sets Xi = Xj + Xk, 0x02 sets Xi = Xj - Xk and 0x03 sets Xi = Xj & Xk, all modulo 2^60.
- R3: Opcode 0x10 sets Ai = Bj + disp, 0x11 sets Ai = Aj + disp, 0x20 sets Bi = Bj + Bk, 0x21 sets Bi = Bj - Bk and 0x22 sets Bi = Bj + disp, all modulo 2^18.
- R4: A write to A1..A5 raises mem_req_o with mem_we_o low and mem_addr_o at the new address in the cycle after acceptance. The word returned with mem_ack_i is placed in Xi.
- R5: A write to A6 or A7 issues a store with mem_we_o high. mem_wdata_o carries Xi as it was when the address write was accepted.
- R6: A write to A0 starts no memory transfer.
- R7: At most one transfer is outstanding. mem_req_o, mem_addr_o and mem_we_o hold until the edge where mem_ack_i is high, and then mem_req_o drops. An address-register write is not accepted while a transfer is outstanding.
- R8: While a load is pending, an instruction that reads or writes the target X register is not accepted. Instructions that do not touch that register are accepted.
- R9: Opcode 0x30 tests Bj. In the cycle after acceptance jz_valid_o is high and jz_taken_o is high exactly when Bj is zero.
- R10: Opcodes other than those listed are accepted and change no register.
- R11: An instruction takes effect at the clock edge where instr_valid_i and instr_ready_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction present |
| instr_ready_o | output | 1 | Instruction can be accepted this cycle |
| instr_op_i | input | 6 | Opcode |
| instr_dst_i | input | 3 | Destination register number i |
| instr_srcj_i | input | 3 | First source register number j |
| instr_srck_i | input | 3 | Second source register number k |
| instr_disp_i | input | 18 | Displacement |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | High for store, low for load |
| mem_addr_o | output | 18 | Word address |
| mem_wdata_o | output | 60 | Store data |
| mem_ack_i | input | 1 | Transfer completes at this edge |
| mem_rdata_i | input | 60 | Load data, valid with mem_ack_i |
| jz_valid_o | output | 1 | Zero test result valid |
| jz_taken_o | output | 1 | Tested index register was zero |

## Verification
A straight-line program with one-cycle memory latency exercises every opcode. It separates operand order (subtract), address base selection (A-relative against B-relative), 18-bit wrap in both directions, and the store of an untouched register after an undefined opcode. A run with long memory latency shows that a second address write and a dependent X read are held, while an independent X operation passes. A counted vector add, driven by the zero test on an index starting at -3, shows that load, compute, store and loop exit together give three correct stores and exactly three iterations.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int XW    = 60;
  localparam int AW    = 18;
  localparam int NREG  = 8;
  localparam int OPW   = 6;
  localparam int ST_LO = 6;  // A6..A7 store, A1..A5 load, A0 none

  typedef enum logic [OPW-1:0] {
    OP_XADD  = 6'h01,
    OP_XSUB  = 6'h02,
    OP_XAND  = 6'h03,
    OP_AADDB = 6'h10,
    OP_AADDA = 6'h11,
    OP_BADD  = 6'h20,
    OP_BSUB  = 6'h21,
    OP_BADDD = 6'h22,
    OP_JZB   = 6'h30
  } op_e;
endpackage

// File: rtl/lsu_reg_bank.sv
module lsu_reg_bank #(
  parameter int W  = 18,
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_a_i,
  input  logic [IW-1:0]       waddr_a_i,
  input  logic [W-1:0]        wdata_a_i,
  input  logic                we_b_i,
  input  logic [IW-1:0]       waddr_b_i,
  input  logic [W-1:0]        wdata_b_i,
  output logic [N-1:0][W-1:0] regs_o
);
  logic [N-1:0][W-1:0] q;

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q[g] <= '0;
      else if (we_b_i && waddr_b_i == IW'(g))      q[g] <= wdata_b_i;
      else if (we_a_i && waddr_a_i == IW'(g))      q[g] <= wdata_a_i;
    end
  end

  assign regs_o = q;

  // load return and instruction result never target the same register together
  p_no_wr_clash_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_a_i && we_b_i) |-> (waddr_a_i != waddr_b_i));
endmodule

// File: rtl/lsu_exec.sv
module lsu_exec
  import lsu_pkg::*;
#(
  parameter int XWD = XW,
  parameter int AWD = AW,
  parameter int N   = NREG,
  parameter int IW  = $clog2(N)
) (
  input  logic [OPW-1:0]        op_i,
  input  logic [IW-1:0]         dst_i,
  input  logic [IW-1:0]         srcj_i,
  input  logic [IW-1:0]         srck_i,
  input  logic [AWD-1:0]        disp_i,
  input  logic [N-1:0][XWD-1:0] x_regs_i,
  input  logic [N-1:0][AWD-1:0] a_regs_i,
  input  logic [N-1:0][AWD-1:0] b_regs_i,
  output logic                  x_we_o,
  output logic                  a_we_o,
  output logic                  b_we_o,
  output logic [XWD-1:0]        x_wdata_o,
  output logic [AWD-1:0]        ab_wdata_o,
  output logic                  jz_o,
  output logic                  jz_hit_o,
  output logic [N-1:0]          x_rd_mask_o,
  output logic [N-1:0]          x_wr_mask_o
);
  logic [XWD-1:0] xj, xk;
  logic [AWD-1:0] aj, bj, bk;

  assign xj = x_regs_i[srcj_i];
  assign xk = x_regs_i[srck_i];
  assign aj = a_regs_i[srcj_i];
  assign bj = b_regs_i[srcj_i];
  assign bk = b_regs_i[srck_i];
  assign jz_hit_o = (bj == '0);

  always_comb begin
    x_we_o      = 1'b0;
    a_we_o      = 1'b0;
    b_we_o      = 1'b0;
    jz_o        = 1'b0;
    x_wdata_o   = '0;
    ab_wdata_o  = '0;
    x_rd_mask_o = '0;
    x_wr_mask_o = '0;
    case (op_i)
      OP_XADD, OP_XSUB, OP_XAND: begin
        x_we_o              = 1'b1;
        x_rd_mask_o[srcj_i] = 1'b1;
        x_rd_mask_o[srck_i] = 1'b1;
        x_wr_mask_o[dst_i]  = 1'b1;
        if (op_i == OP_XADD)      x_wdata_o = xj + xk;
        else if (op_i == OP_XSUB) x_wdata_o = xj - xk;
        else                      x_wdata_o = xj & xk;
      end
      OP_AADDB, OP_AADDA: begin
        a_we_o     = 1'b1;
        ab_wdata_o = (op_i == OP_AADDB) ? bj + disp_i : aj + disp_i;
        // a store reads the paired data register
        if (dst_i >= IW'(ST_LO)) x_rd_mask_o[dst_i] = 1'b1;
      end
      OP_BADD:  begin b_we_o = 1'b1; ab_wdata_o = bj + bk;     end
      OP_BSUB:  begin b_we_o = 1'b1; ab_wdata_o = bj - bk;     end
      OP_BADDD: begin b_we_o = 1'b1; ab_wdata_o = bj + disp_i; end
      OP_JZB:   jz_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/lsu_mem_ctrl.sv
module lsu_mem_ctrl #(
  parameter int XWD = 60,
  parameter int AWD = 18,
  parameter int IW  = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           st_i,
  input  logic [IW-1:0]  idx_i,
  input  logic [AWD-1:0] addr_i,
  input  logic [XWD-1:0] wdata_i,
  output logic           busy_o,
  output logic           pend_ld_o,
  output logic [IW-1:0]  pend_idx_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AWD-1:0] mem_addr_o,
  output logic [XWD-1:0] mem_wdata_o,
  input  logic           mem_ack_i,
  input  logic [XWD-1:0] mem_rdata_i,
  output logic           ld_we_o,
  output logic [IW-1:0]  ld_idx_o,
  output logic [XWD-1:0] ld_data_o
);
  logic           req_q, we_q;
  logic [AWD-1:0] addr_q;
  logic [XWD-1:0] wdata_q;
  logic [IW-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      idx_q   <= '0;
    end else if (start_i) begin
      req_q   <= 1'b1;
      we_q    <= st_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      idx_q   <= idx_i;
    end else if (req_q && mem_ack_i) begin
      req_q   <= 1'b0;
    end
  end

  assign busy_o      = req_q;
  assign pend_ld_o   = req_q && !we_q;
  assign pend_idx_o  = idx_q;
  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign ld_we_o     = req_q && !we_q && mem_ack_i;
  assign ld_idx_o    = idx_q;
  assign ld_data_o   = mem_rdata_i;

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_req_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> !mem_req_o);

  p_load_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !st_i) |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(addr_i)));
endmodule

// File: rtl/areg_lsu.sv
module areg_lsu
  import lsu_pkg::*;
#(
  parameter int XWD = XW,
  parameter int AWD = AW,
  parameter int N   = NREG,
  parameter int IW  = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           instr_valid_i,
  output logic           instr_ready_o,
  input  logic [OPW-1:0] instr_op_i,
  input  logic [IW-1:0]  instr_dst_i,
  input  logic [IW-1:0]  instr_srcj_i,
  input  logic [IW-1:0]  instr_srck_i,
  input  logic [AWD-1:0] instr_disp_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AWD-1:0] mem_addr_o,
  output logic [XWD-1:0] mem_wdata_o,
  input  logic           mem_ack_i,
  input  logic [XWD-1:0] mem_rdata_i,
  output logic           jz_valid_o,
  output logic           jz_taken_o
);
  logic [N-1:0][XWD-1:0] x_regs;
  logic [N-1:0][AWD-1:0] a_regs, b_regs;

  logic           x_we, a_we, b_we, is_jz, jz_hit;
  logic [XWD-1:0] x_wdata;
  logic [AWD-1:0] ab_wdata;
  logic [N-1:0]   x_rd_mask, x_wr_mask;

  logic           busy, pend_ld, ld_we;
  logic [IW-1:0]  pend_idx, ld_idx;
  logic [XWD-1:0] ld_data;

  logic fire, x_hazard, xfer_start, xfer_st;
  logic jz_valid_q, jz_taken_q;

  lsu_exec #(.XWD(XWD), .AWD(AWD), .N(N), .IW(IW)) u_exec (
    .op_i       (instr_op_i),
    .dst_i      (instr_dst_i),
    .srcj_i     (instr_srcj_i),
    .srck_i     (instr_srck_i),
    .disp_i     (instr_disp_i),
    .x_regs_i   (x_regs),
    .a_regs_i   (a_regs),
    .b_regs_i   (b_regs),
    .x_we_o     (x_we),
    .a_we_o     (a_we),
    .b_we_o     (b_we),
    .x_wdata_o  (x_wdata),
    .ab_wdata_o (ab_wdata),
    .jz_o       (is_jz),
    .jz_hit_o   (jz_hit),
    .x_rd_mask_o(x_rd_mask),
    .x_wr_mask_o(x_wr_mask)
  );

  assign x_hazard      = pend_ld && (x_rd_mask[pend_idx] || x_wr_mask[pend_idx]);
  assign instr_ready_o = !x_hazard && !(a_we && busy);
  assign fire          = instr_valid_i && instr_ready_o;
  assign xfer_start    = fire && a_we && (instr_dst_i != '0);
  assign xfer_st       = (instr_dst_i >= IW'(ST_LO));

  lsu_reg_bank #(.W(XWD), .N(N), .IW(IW)) u_xbank (
    .clk_i, .rst_ni,
    .we_a_i   (fire && x_we),
    .waddr_a_i(instr_dst_i),
    .wdata_a_i(x_wdata),
    .we_b_i   (ld_we),
    .waddr_b_i(ld_idx),
    .wdata_b_i(ld_data),
    .regs_o   (x_regs)
  );

  lsu_reg_bank #(.W(AWD), .N(N), .IW(IW)) u_abank (
    .clk_i, .rst_ni,
    .we_a_i   (fire && a_we),
    .waddr_a_i(instr_dst_i),
    .wdata_a_i(ab_wdata),
    .we_b_i   (1'b0),
    .waddr_b_i('0),
    .wdata_b_i('0),
    .regs_o   (a_regs)
  );

  lsu_reg_bank #(.W(AWD), .N(N), .IW(IW)) u_bbank (
    .clk_i, .rst_ni,
    .we_a_i   (fire && b_we),
    .waddr_a_i(instr_dst_i),
    .wdata_a_i(ab_wdata),
    .we_b_i   (1'b0),
    .waddr_b_i('0),
    .wdata_b_i('0),
    .regs_o   (b_regs)
  );

  lsu_mem_ctrl #(.XWD(XWD), .AWD(AWD), .IW(IW)) u_mem (
    .clk_i, .rst_ni,
    .start_i    (xfer_start),
    .st_i       (xfer_st),
    .idx_i      (instr_dst_i),
    .addr_i     (ab_wdata),
    .wdata_i    (x_regs[instr_dst_i]),
    .busy_o     (busy),
    .pend_ld_o  (pend_ld),
    .pend_idx_o (pend_idx),
    .mem_req_o,
    .mem_we_o,
    .mem_addr_o,
    .mem_wdata_o,
    .mem_ack_i,
    .mem_rdata_i,
    .ld_we_o    (ld_we),
    .ld_idx_o   (ld_idx),
    .ld_data_o  (ld_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      jz_valid_q <= 1'b0;
      jz_taken_q <= 1'b0;
    end else begin
      jz_valid_q <= fire && is_jz;
      jz_taken_q <= jz_hit;
    end
  end

  assign jz_valid_o = jz_valid_q;
  assign jz_taken_o = jz_taken_q;

  // A0 write: no transfer follows
  p_a0_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && a_we && instr_dst_i == '0) |=> !mem_req_o);
endmodule

// File: tb/areg_lsu_tb.sv
`timescale 1ns/1ps
module areg_lsu_tb;
  localparam logic [1:0] K_N = 2'd0, K_ST = 2'd1, K_JZ = 2'd2;

  function automatic logic [59:0] mem_f(input int a);
    return {18'(a), 18'(a) ^ 18'h2AAAA, 24'(a * 7 + 1)};
  endfunction

  localparam logic [59:0] V15  = mem_f(32'h15);
  localparam logic [59:0] V20  = mem_f(32'h20);
  localparam logic [59:0] VSUM = V15 + V20;
  localparam logic [59:0] VDIF = V15 - V20;
  localparam logic [59:0] VAND = V15 & V20;

  typedef struct packed {
    logic [5:0]  op;
    logic [2:0]  i, j, k;
    logic [17:0] disp;
    logic [1:0]  kind;
    logic [17:0] eaddr;
    logic [59:0] edata;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{6'h22, 3'd1, 3'd0, 3'd0, 18'h10,    K_N,  18'h0,     60'h0},  // B1=0x10 (R3)
    '{6'h10, 3'd6, 3'd0, 3'd0, 18'h30,    K_ST, 18'h30,    60'h0},  // X6 zero after reset (R1 R5)
    '{6'h10, 3'd1, 3'd1, 3'd0, 18'h5,     K_N,  18'h0,     60'h0},  // load X1 (R4)
    '{6'h10, 3'd2, 3'd0, 3'd0, 18'h20,    K_N,  18'h0,     60'h0},  // load X2
    '{6'h01, 3'd6, 3'd1, 3'd2, 18'h0,     K_N,  18'h0,     60'h0},  // X6=X1+X2
    '{6'h10, 3'd6, 3'd0, 3'd0, 18'h40,    K_ST, 18'h40,    VSUM},   // R2
    '{6'h02, 3'd7, 3'd1, 3'd2, 18'h0,     K_N,  18'h0,     60'h0},
    '{6'h11, 3'd7, 3'd6, 3'd0, 18'h1,     K_ST, 18'h41,    VDIF},   // A-relative (R3)
    '{6'h03, 3'd6, 3'd1, 3'd2, 18'h0,     K_N,  18'h0,     60'h0},
    '{6'h22, 3'd2, 3'd0, 3'd0, 18'h3FFFF, K_N,  18'h0,     60'h0},  // B2=-1
    '{6'h10, 3'd6, 3'd2, 3'd0, 18'h3,     K_ST, 18'h2,     VAND},   // wrap up (R3)
    '{6'h30, 3'd0, 3'd2, 3'd0, 18'h0,     K_JZ, 18'h0,     60'h0},  // R9 not zero
    '{6'h22, 3'd3, 3'd2, 3'd0, 18'h1,     K_N,  18'h0,     60'h0},  // B3=0
    '{6'h30, 3'd0, 3'd3, 3'd0, 18'h0,     K_JZ, 18'h0,     60'h1},  // R9 zero
    '{6'h21, 3'd4, 3'd0, 3'd1, 18'h0,     K_N,  18'h0,     60'h0},  // B4=-0x10
    '{6'h10, 3'd6, 3'd4, 3'd0, 18'h15,    K_ST, 18'h5,     VAND},   // wrap down (R3)
    '{6'h3F, 3'd7, 3'd1, 3'd2, 18'h7,     K_N,  18'h0,     60'h0},  // undefined (R10)
    '{6'h10, 3'd7, 3'd0, 3'd0, 18'h60,    K_ST, 18'h60,    VDIF}    // X7 intact (R10)
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [5:0]  instr_op = '0;
  logic [2:0]  instr_dst = '0, instr_srcj = '0, instr_srck = '0;
  logic [17:0] instr_disp = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [17:0] mem_addr;
  logic [59:0] mem_wdata, mem_rdata = '0;
  logic        jz_valid, jz_taken;

  always #2.5 clk = ~clk;

  areg_lsu u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .instr_valid_i(instr_valid), .instr_ready_o(instr_ready),
    .instr_op_i(instr_op), .instr_dst_i(instr_dst),
    .instr_srcj_i(instr_srcj), .instr_srck_i(instr_srck),
    .instr_disp_i(instr_disp),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .jz_valid_o(jz_valid), .jz_taken_o(jz_taken)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int lat = 1;
  logic [59:0] mem [256];
  logic [17:0] st_addr [64];
  logic [59:0] st_data [64];
  int st_cnt = 0, st_rd = 0;
  logic last_jz_v, last_jz_t;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    int wcnt = 0;
    for (int a = 0; a < 256; a++) mem[a] = mem_f(a);
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        if (wcnt >= lat) begin
          mem_ack = 1'b1;
          wcnt = 0;
          if (mem_we) begin
            mem[mem_addr[7:0]] = mem_wdata;
            if (st_cnt < 64) begin
              st_addr[st_cnt] = mem_addr;
              st_data[st_cnt] = mem_wdata;
            end
            st_cnt++;
          end else begin
            mem_rdata = mem[mem_addr[7:0]];
          end
        end else wcnt++;
      end
    end
  end

  task automatic drive(input logic [5:0] op, input logic [2:0] i, j, k, input logic [17:0] d);
    instr_op = op; instr_dst = i; instr_srcj = j; instr_srck = k; instr_disp = d;
    instr_valid = 1'b1;
  endtask

  // called at a negedge; returns at the negedge after acceptance (R11)
  task automatic issue(input logic [5:0] op, input logic [2:0] i, j, k, input logic [17:0] d);
    drive(op, i, j, k, d);
    #1;
    while (!instr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    last_jz_v = jz_valid;
    last_jz_t = jz_taken;
    instr_valid = 1'b0;
  endtask

  task automatic wait_store(input string req, input logic [17:0] ea, input logic [59:0] ed);
    int t = 0;
    while (st_cnt <= st_rd && t < 200) begin @(negedge clk); t++; end
    #1;
    chk({req, " store addr"}, 64'(st_addr[st_rd]), 64'(ea));
    chk({req, " store data"}, 64'(st_data[st_rd]), 64'(ed));
    st_rd++;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int iters;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 req", 64'(mem_req), 64'(0));
    chk("R1 ready", 64'(instr_ready), 64'(1));
    chk("R1 jz_valid", 64'(jz_valid), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      issue(VEC[v].op, VEC[v].i, VEC[v].j, VEC[v].k, VEC[v].disp);
      if (VEC[v].kind == K_ST) wait_store("R5", VEC[v].eaddr, VEC[v].edata);
      else if (VEC[v].kind == K_JZ) begin
        chk("R9 jz_valid", 64'(last_jz_v), 64'(1));
        chk("R9 jz_taken", 64'(last_jz_t), 64'(VEC[v].edata[0]));
      end
    end
    repeat (3) @(negedge clk);

    // R6 A0 write
    issue(6'h10, 3'd0, 3'd0, 3'd0, 18'h55);
    for (int c = 0; c < 4; c++) begin
      chk("R6 no req", 64'(mem_req), 64'(0));
      @(negedge clk);
    end

    // R4 / R7 serialised transfers with long latency
    lat = 6;
    issue(6'h10, 3'd3, 3'd0, 3'd0, 18'h33);
    chk("R4 req", 64'(mem_req), 64'(1));
    chk("R4 we", 64'(mem_we), 64'(0));
    chk("R4 addr", 64'(mem_addr), 64'(18'h33));
    drive(6'h10, 3'd4, 3'd0, 3'd0, 18'h44);
    #1;
    chk("R7 R11 ready low", 64'(instr_ready), 64'(0));
    @(negedge clk); @(negedge clk);
    chk("R7 addr held", 64'(mem_addr), 64'(18'h33));
    issue(6'h10, 3'd4, 3'd0, 3'd0, 18'h44);
    chk("R7 second req", 64'(mem_req), 64'(1));
    chk("R7 second addr", 64'(mem_addr), 64'(18'h44));
    while (mem_req) @(negedge clk);
    @(negedge clk);

    // R8 pending-load hazard
    issue(6'h10, 3'd1, 3'd0, 3'd0, 18'h21);
    drive(6'h01, 3'd7, 3'd2, 3'd2, 18'h0);
    #1;
    chk("R8 independent ready", 64'(instr_ready), 64'(1));
    issue(6'h01, 3'd7, 3'd2, 3'd2, 18'h0);
    drive(6'h02, 3'd1, 3'd2, 3'd2, 18'h0);
    #1;
    chk("R8 write-after-load blocked", 64'(instr_ready), 64'(0));
    drive(6'h01, 3'd6, 3'd1, 3'd1, 18'h0);
    #1;
    chk("R8 read-after-load blocked", 64'(instr_ready), 64'(0));
    issue(6'h01, 3'd6, 3'd1, 3'd1, 18'h0);
    issue(6'h10, 3'd6, 3'd0, 3'd0, 18'h70);
    wait_store("R8", 18'h70, mem_f(32'h21) + mem_f(32'h21));
    issue(6'h10, 3'd7, 3'd0, 3'd0, 18'h71);
    wait_store("R8", 18'h71, V20 + V20);

    // R9 counted vector add, index from -3
    lat = 1;
    issue(6'h22, 3'd5, 3'd0, 3'd0, 18'h3FFFD);
    iters = 0;
    while (iters < 10) begin
      issue(6'h30, 3'd0, 3'd5, 3'd0, 18'h0);
      if (last_jz_t) break;
      issue(6'h10, 3'd1, 3'd5, 3'd0, 18'h83);
      issue(6'h10, 3'd2, 3'd5, 3'd0, 18'h93);
      issue(6'h01, 3'd6, 3'd1, 3'd2, 18'h0);
      issue(6'h10, 3'd6, 3'd5, 3'd0, 18'hA3);
      wait_store("R4 R5 vector", 18'(32'hA0 + iters), mem_f(32'h80 + iters) + mem_f(32'h90 + iters));
      issue(6'h22, 3'd5, 3'd5, 3'd0, 18'h1);
      iters++;
    end
    chk("R9 loop count", 64'(iters), 64'(3));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule